// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Register

This block freezes an eight-bit parallel input word at one instant and shifts it out serially later. A rising edge on the capture strobe copies the parallel pins into a storage register. That register is separate from the shift register. Holding the active-low load pin low copies the stored word into the shift register. Each rising edge on the shift strobe then moves the word one place toward the serial output, most significant bit first. The vacated low bit is filled from a cascade input. Devices chain by wiring one device's serial output to the next device's cascade input, so two devices yield a 16-bit word read as two bytes.

All strobes are treated as asynchronous pins. They pass through a synchroniser and are edge-detected on the system clock, so every register in the block runs on one clock. An active-low clear empties the shift register and leaves the stored word alone. A select pin drives an output-enable, which the pad's tristate buffer uses so that the serial line can share a bus. The serial value itself stays driven at all times so that a cascade link keeps working.

Top module: `latched_piso`

## Requirements
- R1: A rising edge on `cap_clk` stores `par_d` into the storage register.
- R2: Changes on `par_d` with no `cap_clk` rising edge leave the stored word unchanged.
- R3: While `load_n` is low, the shift register holds the stored word, and `sdo` shows its bit 7.
- R4: Each rising edge on `sh_clk` shifts the register one place toward bit 7. `casc_in` enters bit 0, so `sdo` presents the next lower bit.
- R5: A load has priority over a shift: a `sh_clk` edge while `load_n` is low leaves the loaded word intact.
- R6: With `clr_n` low, the shift register reads all zeros. The storage register is unaffected, so a later load restores the stored word.
- R7: Clear has priority over load: with both `clr_n` and `load_n` low, `sdo` is 0.
- R8: `sdo_oe` is 1 exactly when `sel_n` is 0, and `sdo` carries the shift data regardless of `sel_n`.
- R9: Two devices cascaded, where the upstream `sdo` drives the downstream `casc_in` and the upstream `casc_in` is tied to 0, shift out 16 bits. The downstream byte comes first and the upstream byte second, each MSB first.
- R10: `rst_n` low clears both the storage register and the shift register.
- R11: A change on `load_n` or a strobe edge takes effect on the shift or storage register at the (SYNC_STAGES+1)-th rising clock edge after it. With the default SYNC_STAGES=2, `sdo` is still unchanged after two edges and updated after three. Each strobe level must therefore be held for at least SYNC_STAGES+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of all state |
| par_d | input | WIDTH | Parallel input pins |
| cap_clk | input | 1 | Capture strobe, rising edge active |
| sh_clk | input | 1 | Shift strobe, rising edge active |
| load_n | input | 1 | Active-low parallel load, level sensitive |
| clr_n | input | 1 | Active-low clear of the shift register |
| casc_in | input | 1 | Cascade serial input, fills bit 0 |
| sel_n | input | 1 | Active-low select for the bus output enable |
| sdo | output | 1 | Serial output, bit WIDTH-1 of the shift register |
| sdo_oe | output | 1 | Tristate enable for the bus driver of sdo |

## Verification
The collisions are the hardest cases to reach from the pins. These are a shift edge arriving while load is held, and clear and load being low together. The synchroniser delays every pin, so a plain overlap of short pulses does not line up inside the block. The stimulus holds one control low for longer than the synchroniser depth and completes a full shift-strobe pulse inside that window, or lowers clear and load in the same cycle. The latency requirement is checked by sampling `sdo` on the edge before and the edge after the load takes effect.

// File: rtl/lpiso_pkg.sv
package lpiso_pkg;
  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_LOAD  = 2'd2,
    SH_CLEAR = 2'd3
  } sh_op_e;

  localparam int PIN_CAP   = 0;
  localparam int PIN_SH    = 1;
  localparam int PIN_LOADN = 2;
  localparam int PIN_CLRN  = 3;
  localparam int PIN_COUNT = 4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_in,
  output logic [N-1:0] pins_out
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= IDLE;
    end else begin
      stage_q[0] <= pins_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pins_out = stage_q[STAGES-1];
endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] store
);
  always_ff @(posedge clk) begin
    if (!rst_n)      store <= '0;
    else if (cap_en) store <= d;
  end

  // R1: a detected strobe edge takes the pins
  assert_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> store == $past(d));
  // R2: without an edge the word is frozen
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(store));
endmodule

// File: rtl/shift_chain.sv
module shift_chain
  import lpiso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sh_op_e           op,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (op)
        SH_CLEAR: q <= '0;
        SH_LOAD:  q <= par_in;
        SH_SHIFT: q <= {q[WIDTH-2:0], ser_in};
        default:  q <= q;
      endcase
    end
  end

  // R6: clear empties the register
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op == SH_CLEAR |=> q == '0);
  // R3: load copies the stored word
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op == SH_LOAD |=> q == $past(par_in));
  // R4: shift moves toward the MSB and fills from the cascade input
  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op == SH_SHIFT |=> q == {$past(q[WIDTH-2:0]), $past(ser_in)});
endmodule

// File: rtl/latched_piso.sv
module latched_piso
  import lpiso_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_d,
  input  logic             cap_clk,
  input  logic             sh_clk,
  input  logic             load_n,
  input  logic             clr_n,
  input  logic             casc_in,
  input  logic             sel_n,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b1100;

  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_s;
  logic [1:0]           strobe_prev;
  logic                 cap_rise;
  logic                 sh_rise;
  logic [WIDTH-1:0]     stored;
  logic [WIDTH-1:0]     shreg;
  sh_op_e               op;

  assign pins_raw = {clr_n, load_n, sh_clk, cap_clk};

  pin_sync #(
    .N(PIN_COUNT), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_raw), .pins_out(pins_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_prev <= 2'b00;
    else        strobe_prev <= {pins_s[PIN_SH], pins_s[PIN_CAP]};
  end

  assign cap_rise = pins_s[PIN_CAP] & ~strobe_prev[0];
  assign sh_rise  = pins_s[PIN_SH]  & ~strobe_prev[1];

  always_comb begin
    if (!pins_s[PIN_CLRN])       op = SH_CLEAR;
    else if (!pins_s[PIN_LOADN]) op = SH_LOAD;
    else if (sh_rise)            op = SH_SHIFT;
    else                         op = SH_HOLD;
  end

  capture_reg #(.WIDTH(WIDTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_rise), .d(par_d), .store(stored)
  );

  shift_chain #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .op(op), .par_in(stored),
    .ser_in(casc_in), .q(shreg)
  );

  assign sdo    = shreg[WIDTH-1];
  assign sdo_oe = ~sel_n;

  // R7: clear wins over load at the serial output
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_s[PIN_CLRN] && !pins_s[PIN_LOADN]) |=> !sdo);
  // R5: a shift edge during load does not disturb the loaded word
  assert_load_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_s[PIN_CLRN] && !pins_s[PIN_LOADN] && sh_rise) |=> shreg == $past(stored));
endmodule

// File: tb/sim_latched_piso.sv
module sim_latched_piso;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] d0 = 8'h00, d1 = 8'h00;
  logic cap_clk = 1'b0, sh_clk = 1'b0, load_n = 1'b1, clr_n = 1'b1, sel_n = 1'b0;
  logic sdo0, oe0, sdo1, oe1;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // u0 is nearest the bus, u1 is upstream with its cascade input tied low
  latched_piso u0 (
    .clk(clk), .rst_n(rst_n), .par_d(d0), .cap_clk(cap_clk), .sh_clk(sh_clk),
    .load_n(load_n), .clr_n(clr_n), .casc_in(sdo1), .sel_n(sel_n),
    .sdo(sdo0), .sdo_oe(oe0)
  );
  latched_piso u1 (
    .clk(clk), .rst_n(rst_n), .par_d(d1), .cap_clk(cap_clk), .sh_clk(sh_clk),
    .load_n(load_n), .clr_n(clr_n), .casc_in(1'b0), .sel_n(1'b0),
    .sdo(sdo1), .sdo_oe(oe1)
  );

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture();
    cap_clk = 1'b1; wait_clk(4);
    cap_clk = 1'b0; wait_clk(4);
  endtask

  task automatic do_load();
    load_n = 1'b0; wait_clk(4);
    load_n = 1'b1; wait_clk(4);
  endtask

  task automatic shift_one();
    sh_clk = 1'b1; wait_clk(4);
    sh_clk = 1'b0; wait_clk(4);
  endtask

  task automatic read_word(output logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      w[15-i] = sdo0;
      shift_one();
    end
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R10 sdo in reset", {15'd0, sdo0}, 16'd0);
    rst_n = 1'b1; wait_clk(2);
    check("R10 sdo after reset", {15'd0, sdo0}, 16'd0);
    do_load(); read_word(w);
    check("R10 storage cleared", w, 16'h0000);
  endtask

  task automatic t_pattern(logic [7:0] a, logic [7:0] b);
    logic [15:0] w;
    d0 = a; d1 = b;
    capture(); do_load();
    check("R3 msb on sdo", {15'd0, sdo0}, {15'd0, a[7]});
    read_word(w);
    check("R9 cascade word R1 R4", w, {a, b});
    read_word(w);
    check("R4 zero fill", w, 16'h0000);
  endtask

  task automatic t_ignore();
    logic [15:0] w;
    d0 = 8'h5A; d1 = 8'hE1; capture();
    d0 = 8'h00; d1 = 8'hFF; wait_clk(6);
    do_load(); read_word(w);
    check("R2 pins ignored without strobe", w, 16'h5AE1);
  endtask

  task automatic t_latency();
    d0 = 8'h80; d1 = 8'h00; capture();
    clr_n = 1'b0; wait_clk(4); clr_n = 1'b1; wait_clk(4);
    load_n = 1'b0;
    wait_clk(2);
    check("R11 not yet after two edges", {15'd0, sdo0}, 16'd0);
    wait_clk(1);
    check("R11 loaded after three edges", {15'd0, sdo0}, 16'd1);
    load_n = 1'b1; wait_clk(4);
  endtask

  task automatic t_load_priority();
    logic [15:0] w;
    d0 = 8'hC3; d1 = 8'h96; capture();
    load_n = 1'b0; wait_clk(4);
    shift_one();
    load_n = 1'b1; wait_clk(4);
    read_word(w);
    check("R5 load beats shift", w, 16'hC396);
  endtask

  task automatic t_clear();
    logic [15:0] w;
    d0 = 8'hB7; d1 = 8'h4D; capture(); do_load();
    clr_n = 1'b0; wait_clk(4);
    check("R6 sdo cleared", {15'd0, sdo0}, 16'd0);
    read_word(w);
    check("R6 shift reg empty", w, 16'h0000);
    clr_n = 1'b1; wait_clk(4);
    do_load(); read_word(w);
    check("R6 storage kept", w, 16'hB74D);
  endtask

  task automatic t_clear_priority();
    d0 = 8'hC3; d1 = 8'h00; capture();
    clr_n = 1'b0; load_n = 1'b0; wait_clk(4);
    check("R7 clear beats load", {15'd0, sdo0}, 16'd0);
    clr_n = 1'b1; wait_clk(4);
    check("R7 load after clear release", {15'd0, sdo0}, 16'd1);
    load_n = 1'b1; wait_clk(4);
  endtask

  task automatic t_select();
    sel_n = 1'b1; wait_clk(1);
    check("R8 oe off when deselected", {15'd0, oe0}, 16'd0);
    check("R8 sdo still driven", {15'd0, sdo0}, 16'd1);
    sel_n = 1'b0; wait_clk(1);
    check("R8 oe on when selected", {15'd0, oe0}, 16'd1);
  endtask

  initial begin
    wait_clk(4);
    t_reset();
    t_pattern(8'hA5, 8'h3C);
    t_pattern(8'h81, 8'h7E);
    t_pattern(8'hFF, 8'h00);
    t_ignore();
    t_latency();
    t_load_priority();
    t_clear();
    t_clear_priority();
    t_select();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule